// File: doc/BRIEF.md
# Configurable Async Serial Receiver

This block recovers characters from an asynchronous serial line. The line is sampled on a sample-enable pulse that arrives at sixteen times the bit rate. The frame format is set at run time by a handful of control inputs. These select a word length of 5 to 8 bits and an optional parity bit with a choice of four parity rules. Each frame ends with at least one stop bit.

Each received character goes into a 16-entry show-ahead FIFO, together with its own parity-error and framing-error flags. The FIFO presents its oldest entry, and the fill count, on the outputs at all times. A data-ready request is raised while the fill count is at or above a selectable threshold. A separate time-out request signals that a small number of characters has been sitting unread while the line is quiet. The sample-rate generator and any register file sit outside this block.

Top module: `serial_rx_fifo`

## Requirements
- R1: `wlen` selects the number of data bits: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8. Data bits arrive least significant first, and `rd_data` bits above the word length read as zero.
- R2: With `par_en` low, no parity bit is expected after the data, and `rd_perr` is 0 for every character.
- R3: With `par_en` high and `par_force` low, the total count of ones in the data and parity bits must be odd when `par_even` is 0 and even when `par_even` is 1. Otherwise `rd_perr` is 1.
- R4: With `par_en` and `par_force` both high, the parity bit must equal the inverse of `par_even`. Otherwise `rd_perr` is 1.
- R5: `rd_ferr` is 1 when the first stop bit samples low and 0 when it samples high. Stop bits after the first are never checked.
- R6: A low pulse on `rxd` that reads high again at mid-bit, 8 sample ticks after the falling edge, is discarded. No character is stored.
- R7: The FIFO holds 16 entries and shows its oldest entry on `rd_data`, `rd_perr` and `rd_ferr`. A pulse on `rd_en` removes that entry. `fill` counts the entries. A character that arrives while the FIFO is full is dropped.
- R8: `rx_req` is high exactly while `fill` is at or above the level selected by `trig_sel`: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14.
- R9: `tmo_req` rises when the FIFO is non-empty and no character has been stored or read for 4 character times, counted in sample ticks. A FIFO read clears it.
- R10: After reset, `fill` is 0 and both `rx_req` and `tmo_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Sample enable at 16x the bit rate |
| rxd | input | 1 | Serial line, idle high |
| wlen | input | 2 | Word length select |
| par_en | input | 1 | Parity bit present |
| par_even | input | 1 | Even parity / forced-0 select |
| par_force | input | 1 | Forced parity mode |
| trig_sel | input | 2 | Data-ready threshold select |
| rd_en | input | 1 | Pop the oldest FIFO entry |
| rd_data | output | 8 | Oldest received character |
| rd_perr | output | 1 | Parity error of the oldest character |
| rd_ferr | output | 1 | Framing error of the oldest character |
| fill | output | 5 | FIFO entry count |
| rx_req | output | 1 | Data-ready request |
| tmo_req | output | 1 | Time-out request |

## Verification
The assertions assume that the format controls stay unchanged during a frame. They also assume that `rxd` holds each bit for a whole bit time, so that the mid-bit sample and the glitch rule see a clean level. The stimulus changes the format only between frames, while the line idles high. Every bit is driven for exactly sixteen sample ticks, and a bad stop bit is kept short so that its tail ends as a rejected glitch and never as a new start.

// File: rtl/serial_rx_fifo.sv
module serial_rx_fifo #(
  parameter int DEPTH = 16,
  parameter int OSR   = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tick,
  input  logic                     rxd,
  input  logic [1:0]               wlen,
  input  logic                     par_en,
  input  logic                     par_even,
  input  logic                     par_force,
  input  logic [1:0]               trig_sel,
  input  logic                     rd_en,
  output logic [7:0]               rd_data,
  output logic                     rd_perr,
  output logic                     rd_ferr,
  output logic [$clog2(DEPTH):0]   fill,
  output logic                     rx_req,
  output logic                     tmo_req
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(OSR);
  localparam int TW = 12;

  typedef enum logic [2:0] {IDLE, START, DATA, PAR, STOP} st_t;
  st_t st;

  logic [CW-1:0] tcnt;
  logic [2:0]    bidx;
  logic [7:0]    sh;
  logic          pbit;

  wire [3:0] nbits = 4'd5 + {2'b00, wlen};
  wire       mid   = tick && (tcnt == CW'(OSR - 1));
  wire       half  = tick && (tcnt == CW'(OSR / 2 - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= IDLE;
      tcnt <= '0;
      bidx <= '0;
      sh   <= '0;
      pbit <= 1'b0;
    end else begin
      if (tick) tcnt <= tcnt + 1'b1;
      case (st)
        IDLE:  if (tick && !rxd) begin st <= START; tcnt <= '0; end
        START: if (half) begin
                 tcnt <= '0;
                 bidx <= '0;
                 st   <= rxd ? IDLE : DATA;
               end
        DATA:  if (mid) begin
                 sh   <= {rxd, sh[7:1]};
                 bidx <= bidx + 1'b1;
                 if (bidx == 3'(nbits - 4'd1)) st <= par_en ? PAR : STOP;
               end
        PAR:   if (mid) begin pbit <= rxd; st <= STOP; end
        STOP:  if (mid) st <= IDLE;
        default: st <= IDLE;
      endcase
    end
  end

  wire [7:0] dal  = sh >> (4'd8 - nbits);
  wire       pexp = par_force ? ~par_even : (^dal ^ ~par_even);
  wire       perr = par_en && (pbit != pexp);

  logic [9:0]    mem [DEPTH];
  logic [AW-1:0] wp, rp;

  wire full = (fill == (AW+1)'(DEPTH));
  wire push = (st == STOP) && mid && !full;
  wire pop  = rd_en && (fill != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp   <= '0;
      rp   <= '0;
      fill <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      fill <= fill + (AW+1)'(push) - (AW+1)'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= {!rxd, perr, dal};
  end

  assign rd_data = mem[rp][7:0];
  assign rd_perr = mem[rp][8];
  assign rd_ferr = mem[rp][9];

  logic [4:0] lvl;
  always_comb begin
    case (trig_sel)
      2'b00:   lvl = 5'd1;
      2'b01:   lvl = 5'd4;
      2'b10:   lvl = 5'd8;
      default: lvl = 5'd14;
    endcase
  end
  assign rx_req = ({{(5 > AW+1 ? 0 : AW+1-5){1'b0}}, fill} >= (AW+1)'(lvl));

  logic [TW-1:0] tocnt;
  wire  [3:0]    fbits = nbits + 4'd2 + {3'b000, par_en};
  wire  [TW-1:0] tolim = TW'(fbits) * TW'(4 * OSR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tocnt   <= '0;
      tmo_req <= 1'b0;
    end else begin
      if (push || pop || fill == '0) tocnt <= '0;
      else if (tick && tocnt != tolim) tocnt <= tocnt + 1'b1;
      if (pop) tmo_req <= 1'b0;
      else if (fill != '0 && tocnt == tolim) tmo_req <= 1'b1;
    end
  end

  // R7
  fill_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= (AW+1)'(DEPTH));
  // R7
  pop_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |=> fill == $past(fill) - 1'b1);
  // R7
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !rd_en) |=> full);
  // R6
  glitch_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == START && half && rxd && !rd_en) |=> fill == $past(fill));
  // R9
  tmo_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> !tmo_req);
endmodule

// File: tb/test_serial_rx_fifo.sv
module test_serial_rx_fifo;
  logic clk = 0, rst_n = 0, tick = 0, rxd = 1;
  logic [1:0] wlen = 2'b11, trig_sel = 2'b00;
  logic par_en = 0, par_even = 0, par_force = 0, rd_en = 0;
  logic [7:0] rd_data;
  logic rd_perr, rd_ferr, rx_req, tmo_req;
  logic [4:0] fill;
  int checks = 0, errors = 0;

  serial_rx_fifo i_serial_rx_fifo (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd), .wlen(wlen),
    .par_en(par_en), .par_even(par_even), .par_force(par_force),
    .trig_sel(trig_sel), .rd_en(rd_en), .rd_data(rd_data),
    .rd_perr(rd_perr), .rd_ferr(rd_ferr), .fill(fill),
    .rx_req(rx_req), .tmo_req(tmo_req));

  always #5 clk = ~clk;
  always @(negedge clk) if (rst_n) tick <= ~tick;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic bit_out(bit b);
    rxd = b;
    repeat (32) @(negedge clk);
  endtask

  task automatic send(logic [7:0] d, int nb, bit pen, bit pval, bit stop_ok);
    bit_out(0);
    for (int i = 0; i < nb; i++) bit_out(d[i]);
    if (pen) bit_out(pval);
    if (stop_ok) bit_out(1);
    else begin
      rxd = 0; repeat (20) @(negedge clk);
      rxd = 1; repeat (44) @(negedge clk);
    end
    bit_out(1);
  endtask

  task automatic pop_one();
    rd_en = 1; @(negedge clk); rd_en = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] vals [4];
    vals[0] = 8'h00; vals[1] = 8'hFF; vals[2] = 8'hA5; vals[3] = 8'h3C;
    repeat (3) @(negedge clk);
    // R10
    check("R10 fill", int'(fill), 0);
    check("R10 rx_req", int'(rx_req), 0);
    check("R10 tmo_req", int'(tmo_req), 0);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 R2 R3 R4: sweep of word lengths and parity modes
    for (int w = 0; w < 4; w++) begin
      for (int pm = 0; pm < 5; pm++) begin
        for (int v = 0; v < 5; v++) begin
          int nb;
          logic [7:0] d, dm;
          bit pv, bad;
          if (v == 4 && pm == 0) continue;
          nb = 5 + w;
          wlen = 2'(w);
          par_en = (pm != 0);
          par_even = (pm == 2 || pm == 4);
          par_force = (pm >= 3);
          d = (v == 4) ? 8'h5A : vals[v];
          dm = d & 8'((1 << nb) - 1);
          pv = par_force ? ~par_even : (par_even ? ^dm : ~^dm);
          bad = (v == 4);
          send(d, nb, par_en, pv ^ bad, 1);
          check("R7 fill after frame", int'(fill), 1);
          check("R1 data", int'(rd_data), int'(dm));
          if (pm == 0) check("R2 no parity err", int'(rd_perr), 0);
          else if (pm < 3) check("R3 parity", int'(rd_perr), int'(bad));
          else check("R4 forced parity", int'(rd_perr), int'(bad));
          check("R5 ferr clean", int'(rd_ferr), 0);
          pop_one();
        end
      end
    end

    wlen = 2'b11; par_en = 0; par_even = 0; par_force = 0;
    // R5: bad stop bit
    send(8'h81, 8, 0, 0, 0);
    check("R5 ferr set", int'(rd_ferr), 1);
    check("R5 data", int'(rd_data), 8'h81);
    check("R5 single entry", int'(fill), 1);
    pop_one();
    check("R7 empty after pop", int'(fill), 0);

    // R6: glitch
    rxd = 0; repeat (8) @(negedge clk); rxd = 1;
    repeat (60) @(negedge clk);
    check("R6 glitch ignored", int'(fill), 0);
    send(8'h42, 8, 0, 0, 1);
    check("R6 next frame ok", int'(rd_data), 8'h42);
    pop_one();

    // R7 R8: fill to full, overflow, trigger levels
    for (int k = 1; k <= 17; k++) begin
      int lv [4];
      int ef;
      lv[0] = 1; lv[1] = 4; lv[2] = 8; lv[3] = 14;
      send(8'(k), 8, 0, 0, 1);
      ef = (k > 16) ? 16 : k;
      check("R7 fill count", int'(fill), ef);
      for (int t = 0; t < 4; t++) begin
        trig_sel = 2'(t); #1;
        check("R8 trigger", int'(rx_req), int'(ef >= lv[t]));
      end
    end
    for (int k = 1; k <= 16; k++) begin
      check("R7 fifo order", int'(rd_data), k);
      pop_one();
    end
    check("R7 drained", int'(fill), 0);
    trig_sel = 2'b00; #1;
    check("R8 empty no req", int'(rx_req), 0);

    // R9: time-out (8N1: 4*16*10 ticks = 1280 clocks)
    send(8'h77, 8, 0, 0, 1);
    repeat (1240 - 32 - 16) @(negedge clk);
    check("R9 no early tmo", int'(tmo_req), 0);
    repeat (80) @(negedge clk);
    check("R9 tmo raised", int'(tmo_req), 1);
    pop_one();
    check("R9 tmo cleared", int'(tmo_req), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule